// File: doc/BRIEF.md
# Scrambled Grayscale PWM Generator

This block turns sixteen latched grayscale words into sixteen on/off channel enables, all timed by one grayscale clock. In plain (linear) counting, each channel is on for the first `value` clocks of a period of 2^D clocks, where D is 12 or 16. The scrambled modes shorten the time between refreshes and so reduce visible flicker. Each value is split into a high field and a 6-bit low field. The high field is replayed in a number of short sub-cycles, and the low field is played out once at the end.

New words arrive on a bus together with a one-clock global-latch strobe, which is synchronous to the grayscale clock. In immediate mode the words take effect at once. In cycle-aligned mode they are captured into a shadow store and applied only at the boundary between two full cycles, so no channel ever shows a mix of old and new data inside a cycle. An end-of-cycle flag marks the last clock of every full cycle. Any change of depth or counting mode restarts the cycle from its first slot.

Top module: `scrambled_pwm_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released before any word is latched, every `chan_on_o` bit is 0 and `cycle_end_o` is 0.
- R2: With `cnt_mode_i` = 2'b11 (linear), a full cycle lasts 2^D clocks. In slot t (t = 0 .. 2^D-1) a channel is on exactly when t < its value.
- R3: `depth16_i` = 0 selects D = 12: bits 15:12 of each word are ignored and a channel behaves as if they were 0. `depth16_i` = 1 selects D = 16 and uses all 16 bits.
- R4: With `cnt_mode_i` = 2'b00, a cycle is 64 high sub-cycles of 2^(D-6) one-clock ticks each, followed by one low sub-cycle of 64 clocks. The channel is on in a high tick k when k < word[D-1:6], and on in low clock k when k < word[5:0].
- R5: With `cnt_mode_i` = 2'b01, there are 16 high sub-cycles and each tick lasts 4 clocks. The low sub-cycle is unchanged.
- R6: With `cnt_mode_i` = 2'b10, there are 4 high sub-cycles and each tick lasts 16 clocks. The low sub-cycle is unchanged.
- R7: Over one full cycle in any mode, a channel is on for exactly value clocks (the value taken at the selected depth). A value of 0 never turns the channel on.
- R8: `cycle_end_o` is high for exactly one clock per full cycle: the last clock of the cycle.
- R9: With `manual_sync_i` = 1, the words present at a `glatch_i` edge drive the channels from the slot that follows that edge.
- R10: With `manual_sync_i` = 0, a `glatch_i` edge captures the words. The channels keep the old words until the cycle in progress ends, and use the captured words from the first slot of the next cycle. Later changes on `gs_words_i` have no effect.
- R11: When `depth16_i` or `cnt_mode_i` changes, the next clock edge restarts the cycle at slot 0 under the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Grayscale clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gs_words_i | input | 256 | Sixteen 16-bit grayscale words, channel n in bits 16n+15:16n |
| depth16_i | input | 1 | 1 = 16-bit depth, 0 = 12-bit depth |
| cnt_mode_i | input | 2 | 00/01/10 scrambled with 64/16/4 sub-cycles, 11 linear |
| manual_sync_i | input | 1 | 1 = immediate word update, 0 = update at cycle boundary |
| glatch_i | input | 1 | One-clock global-latch strobe |
| chan_on_o | output | 16 | Per-channel on/off enable |
| cycle_end_o | output | 1 | High during the last clock of each full cycle |

## Verification
The bench measures whole cycles in each counting mode and at both depths. It counts the on-clocks, the number of on-runs and the length of the first run for selected values.

- A wrong tick prescale or sub-cycle count changes the run count or the first-run length.
- A wrong field split makes the on-clock total differ from the value.
- A depth mask that leaks the upper bits shows up on a word whose high nibble is set.

For synchronisation, the bench strobes new words in the middle of a cycle in both modes. A cycle-aligned design that applied them early would switch a channel off within that same cycle, and one that captured late would pick up the garbage written to the bus after the strobe. A mid-cycle mode change must restart the cycle. If it does not, the end flag appears at the wrong slot count.

// File: rtl/spg_pkg.sv
package spg_pkg;

  typedef enum logic [1:0] {
    MODE_SPREAD64 = 2'b00,
    MODE_SPREAD16 = 2'b01,
    MODE_SPREAD4  = 2'b10,
    MODE_LINEAR   = 2'b11
  } cnt_mode_e;

  localparam int SUB_W = 6;  // holds up to 64 high sub-cycles
  localparam int PRE_W = 4;  // holds a tick prescale of up to 16

  // last value of the tick prescaler for each mode
  function automatic logic [PRE_W-1:0] pre_last(input logic [1:0] mode);
    case (mode)
      MODE_SPREAD16: pre_last = PRE_W'(3);
      MODE_SPREAD4:  pre_last = PRE_W'(15);
      default:       pre_last = '0;
    endcase
  endfunction

  // index of the last high sub-cycle for each mode
  function automatic logic [SUB_W-1:0] sub_last(input logic [1:0] mode);
    case (mode)
      MODE_SPREAD64: sub_last = SUB_W'(63);
      MODE_SPREAD16: sub_last = SUB_W'(15);
      MODE_SPREAD4:  sub_last = SUB_W'(3);
      default:       sub_last = '0;
    endcase
  endfunction

endpackage

// File: rtl/spg_timebase.sv
module spg_timebase
  import spg_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 12,
  parameter int LSB_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              depth16_i,
  input  logic [1:0]        mode_i,
  output logic [WORD_W-1:0] tick_o,
  output logic              linear_o,
  output logic              lsb_phase_o,
  output logic              depth16_o,
  output logic              last_o
);

  localparam logic [WORD_W-1:0] LIN_MAX_WIDE   = {WORD_W{1'b1}};
  localparam logic [WORD_W-1:0] LIN_MAX_NARROW = WORD_W'((1 << NARROW_W) - 1);
  localparam logic [WORD_W-1:0] MSB_MAX_WIDE   = WORD_W'((1 << (WORD_W - LSB_W)) - 1);
  localparam logic [WORD_W-1:0] MSB_MAX_NARROW = WORD_W'((1 << (NARROW_W - LSB_W)) - 1);
  localparam logic [WORD_W-1:0] LSB_MAX        = WORD_W'((1 << LSB_W) - 1);

  logic [PRE_W-1:0]  pre_q,  pre_d;
  logic [WORD_W-1:0] tick_q, tick_d;
  logic [SUB_W-1:0]  sub_q,  sub_d;
  logic              lsb_q,  lsb_d;
  logic [2:0]        cfg_q,  cfg_d;

  logic [1:0]        mode_q;
  logic              depth_q;
  logic              lin;
  logic              restart;
  logic              step;
  logic [WORD_W-1:0] tick_max;

  assign mode_q  = cfg_q[1:0];
  assign depth_q = cfg_q[2];
  assign lin     = (mode_q == MODE_LINEAR);
  assign cfg_d   = {depth16_i, mode_i};
  assign restart = (cfg_d != cfg_q);
  assign step    = lin || lsb_q || (pre_q == pre_last(mode_q));

  always_comb begin
    if (lin)        tick_max = depth_q ? LIN_MAX_WIDE : LIN_MAX_NARROW;
    else if (lsb_q) tick_max = LSB_MAX;
    else            tick_max = depth_q ? MSB_MAX_WIDE : MSB_MAX_NARROW;
  end

  // next-state logic
  always_comb begin
    pre_d  = pre_q;
    tick_d = tick_q;
    sub_d  = sub_q;
    lsb_d  = lsb_q;
    if (restart) begin
      pre_d  = '0;
      tick_d = '0;
      sub_d  = '0;
      lsb_d  = 1'b0;
    end else if (!step) begin
      pre_d = pre_q + 1'b1;
    end else begin
      pre_d = '0;
      if (tick_q != tick_max) begin
        tick_d = tick_q + 1'b1;
      end else begin
        tick_d = '0;
        if (lsb_q) begin
          lsb_d = 1'b0;
        end else if (!lin) begin
          if (sub_q == sub_last(mode_q)) begin
            sub_d = '0;
            lsb_d = 1'b1;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= '0;
      sub_q  <= '0;
      lsb_q  <= 1'b0;
      cfg_q  <= {1'b0, MODE_LINEAR};
    end else begin
      pre_q  <= pre_d;
      tick_q <= tick_d;
      sub_q  <= sub_d;
      lsb_q  <= lsb_d;
      cfg_q  <= cfg_d;
    end
  end

  assign tick_o      = tick_q;
  assign linear_o    = lin;
  assign lsb_phase_o = lsb_q;
  assign depth16_o   = depth_q;
  assign last_o      = (lin && tick_q == tick_max) || (lsb_q && tick_q == LSB_MAX);

  // R8: the end-of-cycle clock is never followed by another one
  assert_single_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !last_o);

  // R8: a cycle end without a restart lands on slot 0 of a fresh cycle
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !restart) |=> (tick_q == '0 && sub_q == '0 && !lsb_q && pre_q == '0));

  // R11: a change of setting restarts the counting
  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tick_q == '0 && sub_q == '0 && !lsb_q && pre_q == '0));

  // R4: the low sub-cycle only ever runs in a scrambled mode
  assert_lsb_scrambled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lsb_q |-> !lin);

endmodule

// File: rtl/spg_wordbank.sv
module spg_wordbank #(
  parameter int NCH    = 16,
  parameter int WORD_W = 16,
  localparam int BUS_W = NCH * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] words_i,
  input  logic             glatch_i,
  input  logic             manual_i,
  input  logic             last_i,
  output logic [BUS_W-1:0] active_o
);

  logic [BUS_W-1:0] shadow_q;
  logic [BUS_W-1:0] active_q, active_d;
  logic             pend_q,   pend_d;
  logic             shadow_en;
  logic             direct_ld;
  logic             apply_pend;

  assign direct_ld  = glatch_i && manual_i;
  assign shadow_en  = glatch_i && !manual_i;
  assign apply_pend = pend_q && last_i && !direct_ld;

  always_comb begin
    active_d = active_q;
    pend_d   = pend_q;
    if (direct_ld) begin
      active_d = words_i;
      pend_d   = 1'b0;
    end else begin
      if (apply_pend) begin
        active_d = shadow_q;
        pend_d   = 1'b0;
      end
      if (shadow_en) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else if (shadow_en) shadow_q <= words_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      pend_q   <= pend_d;
    end
  end

  assign active_o = active_q;

  // R9: an immediate strobe puts the bus words into effect at that edge
  assert_direct_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (glatch_i && manual_i) |=> active_q == $past(words_i));

  // R10: outside a direct strobe, the words change only at a cycle end
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(glatch_i && manual_i) && !last_i) |=> $stable(active_q));

  // R10: a pending capture is what gets applied at the boundary
  assert_apply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && last_i && !(glatch_i && manual_i)) |=> active_q == $past(shadow_q));

endmodule

// File: rtl/spg_chan.sv
module spg_chan #(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 12,
  parameter int LSB_W    = 6
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] tick_i,
  input  logic              linear_i,
  input  logic              lsb_phase_i,
  input  logic              depth16_i,
  output logic              on_o
);

  localparam logic [WORD_W-1:0] NARROW_MASK = WORD_W'((1 << NARROW_W) - 1);
  localparam logic [WORD_W-1:0] LSB_MASK    = WORD_W'((1 << LSB_W) - 1);

  logic [WORD_W-1:0] eff;
  logic [WORD_W-1:0] field;

  assign eff = depth16_i ? word_i : (word_i & NARROW_MASK);

  always_comb begin
    if (linear_i)         field = eff;
    else if (lsb_phase_i) field = eff & LSB_MASK;
    else                  field = eff >> LSB_W;
  end

  assign on_o = (tick_i < field);

endmodule

// File: rtl/scrambled_pwm_gen.sv
module scrambled_pwm_gen #(
  parameter int NCH      = 16,
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 12,
  parameter int LSB_W    = 6,
  localparam int BUS_W   = NCH * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] gs_words_i,
  input  logic             depth16_i,
  input  logic [1:0]       cnt_mode_i,
  input  logic             manual_sync_i,
  input  logic             glatch_i,
  output logic [NCH-1:0]   chan_on_o,
  output logic             cycle_end_o
);

  logic [WORD_W-1:0] tick;
  logic              linear;
  logic              lsb_phase;
  logic              depth16;
  logic              last;
  logic [BUS_W-1:0]  active;

  spg_timebase #(
    .WORD_W  (WORD_W),
    .NARROW_W(NARROW_W),
    .LSB_W   (LSB_W)
  ) u_timebase (
    .clk        (clk),
    .rst_n      (rst_n),
    .depth16_i  (depth16_i),
    .mode_i     (cnt_mode_i),
    .tick_o     (tick),
    .linear_o   (linear),
    .lsb_phase_o(lsb_phase),
    .depth16_o  (depth16),
    .last_o     (last)
  );

  spg_wordbank #(
    .NCH   (NCH),
    .WORD_W(WORD_W)
  ) u_wordbank (
    .clk     (clk),
    .rst_n   (rst_n),
    .words_i (gs_words_i),
    .glatch_i(glatch_i),
    .manual_i(manual_sync_i),
    .last_i  (last),
    .active_o(active)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    spg_chan #(
      .WORD_W  (WORD_W),
      .NARROW_W(NARROW_W),
      .LSB_W   (LSB_W)
    ) u_chan (
      .word_i     (active[g*WORD_W +: WORD_W]),
      .tick_i     (tick),
      .linear_i   (linear),
      .lsb_phase_i(lsb_phase),
      .depth16_i  (depth16),
      .on_o       (chan_on_o[g])
    );

    // R7: a zero word never drives its channel on
    assert_zero_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active[g*WORD_W +: WORD_W] == '0) |-> !chan_on_o[g]);
  end

  assign cycle_end_o = last;

endmodule

// File: tb/scrambled_pwm_gen_tb.sv
module scrambled_pwm_gen_tb;
  localparam int NCH = 16;
  localparam int W   = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NCH*W-1:0] gs_words_i;
  logic             depth16_i;
  logic [1:0]       cnt_mode_i;
  logic             manual_sync_i;
  logic             glatch_i;
  logic [NCH-1:0]   chan_on_o;
  logic             cycle_end_o;

  logic [W-1:0] words [NCH];
  int checks = 0;
  int errors = 0;
  int on_cnt    [NCH];
  int runs      [NCH];
  int first_run [NCH];

  always #10 clk = ~clk;

  for (genvar g = 0; g < NCH; g++) begin : g_pack
    assign gs_words_i[g*W +: W] = words[g];
  end

  scrambled_pwm_gen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .gs_words_i   (gs_words_i),
    .depth16_i    (depth16_i),
    .cnt_mode_i   (cnt_mode_i),
    .manual_sync_i(manual_sync_i),
    .glatch_i     (glatch_i),
    .chan_on_o    (chan_on_o),
    .cycle_end_o  (cycle_end_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_a();
    words[0] = 16'd0;    words[1] = 16'd1;   words[2] = 16'd4095; words[3] = 16'd323;
    words[4] = 16'd64;   words[5] = 16'd63;  words[6] = 16'hF123; words[7] = 16'd2048;
    for (int i = 8; i < NCH; i++) words[i] = W'(i * 251);
  endtask

  task automatic set_b();
    words[0] = 16'hFFFF; words[1] = 16'h1234; words[2] = 16'h0000; words[3] = 16'h0040;
    words[4] = 16'h8000;
    for (int i = 5; i < NCH; i++) words[i] = W'(i * 4001);
  endtask

  task automatic strobe();
    @(negedge clk);
    glatch_i = 1'b1;
    @(negedge clk);
    glatch_i = 1'b0;
  endtask

  // one full cycle, sampled at falling edges; optionally wait for a boundary first
  task automatic run_cycle(input int len, input bit align, input string req);
    int ends;
    int end_last;
    bit prev [NCH];
    if (align) begin
      do @(negedge clk); while (!cycle_end_o);
    end
    ends = 0;
    end_last = 0;
    for (int c = 0; c < NCH; c++) begin
      on_cnt[c] = 0; runs[c] = 0; first_run[c] = 0; prev[c] = 1'b0;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (chan_on_o[c]) begin
          on_cnt[c]++;
          if (!prev[c]) runs[c]++;
          if (runs[c] == 1) first_run[c]++;
        end
        prev[c] = chan_on_o[c];
      end
      if (cycle_end_o) ends++;
      if (i == len - 1) end_last = int'(cycle_end_o);
    end
    chk({req, " R8"}, "end pulses in cycle", ends, 1);
    chk({req, " R8"}, "end on last slot", end_last, 1);
  endtask

  task automatic check_counts(input bit d16, input string req);
    for (int c = 0; c < NCH; c++)
      chk({req, " R7"}, $sformatf("ch%0d on clocks", c), on_cnt[c],
          d16 ? int'(words[c]) : int'(words[c] & 16'h0FFF));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", int'(chan_on_o), 0);
    chk("R1", "end in reset", int'(cycle_end_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "outputs after release", int'(chan_on_o), 0);
  endtask

  task automatic t_linear12();
    set_a();
    strobe();
    run_cycle(4096, 1'b1, "R2");
    check_counts(1'b0, "R2");
    chk("R3", "ch6 upper nibble ignored", on_cnt[6], 291);
    chk("R2", "ch3 runs", runs[3], 1);
    chk("R2", "ch3 first run", first_run[3], 323);
  endtask

  task automatic t_spread(input logic [1:0] mode, input int r3, input int f3, input int r4,
                          input int f4, input string req);
    @(negedge clk);
    cnt_mode_i = mode;
    run_cycle(4160, 1'b0, req);
    check_counts(1'b0, req);
    chk(req, "ch3 runs", runs[3], r3);
    chk(req, "ch3 first run", first_run[3], f3);
    chk(req, "ch4 runs", runs[4], r4);
    chk(req, "ch4 first run", first_run[4], f4);
    chk(req, "ch5 runs", runs[5], 1);
    chk(req, "ch5 first run", first_run[5], 63);
  endtask

  task automatic t_wide();
    set_b();
    @(negedge clk);
    glatch_i = 1'b1;
    @(negedge clk);
    glatch_i = 1'b0;
    depth16_i = 1'b1;
    cnt_mode_i = 2'b00;
    run_cycle(65600, 1'b0, "R3 R4");
    check_counts(1'b1, "R3");
    chk("R4", "ch0 runs", runs[0], 65);
    chk("R4", "ch0 first run", first_run[0], 1023);
    chk("R4", "ch3 runs", runs[3], 64);
    chk("R4", "ch4 first run", first_run[4], 512);
  endtask

  task automatic t_manual();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) words[c] = '0;
    glatch_i = 1'b1;
    depth16_i = 1'b0;
    cnt_mode_i = 2'b11;
    @(negedge clk);          // slot 0 of a restarted linear cycle
    glatch_i = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9", "ch0 before strobe", int'(chan_on_o[0]), 0);
    words[0] = 16'd4095;
    glatch_i = 1'b1;
    @(negedge clk);
    glatch_i = 1'b0;
    chk("R9", "ch0 after strobe", int'(chan_on_o[0]), 1);
    chk("R9", "ch1 after strobe", int'(chan_on_o[1]), 0);
  endtask

  task automatic t_auto();
    int ch0_off;
    int ch1_on;
    @(negedge clk);
    manual_sync_i = 1'b0;
    repeat (8) @(negedge clk);
    words[0] = 16'd0;
    words[1] = 16'd100;
    glatch_i = 1'b1;
    @(negedge clk);
    glatch_i = 1'b0;
    words[1] = 16'd5;
    ch0_off = 0;
    ch1_on = 0;
    do begin
      @(negedge clk);
      if (!chan_on_o[0]) ch0_off++;
      if (chan_on_o[1]) ch1_on++;
    end while (!cycle_end_o);
    chk("R10", "ch0 off slots before boundary", ch0_off, 1);
    chk("R10", "ch1 on slots before boundary", ch1_on, 0);
    run_cycle(4096, 1'b0, "R10");
    chk("R10", "ch0 after boundary", on_cnt[0], 0);
    chk("R10", "ch1 captured word", on_cnt[1], 100);
  endtask

  task automatic t_restart();
    repeat (1000) @(negedge clk);
    cnt_mode_i = 2'b01;
    run_cycle(4160, 1'b0, "R11");
    chk("R11", "ch1 clocks", on_cnt[1], 100);
    chk("R5", "ch1 runs", runs[1], 17);
    chk("R5", "ch1 first run", first_run[1], 4);
    chk("R11", "ch0 clocks", on_cnt[0], 0);
  endtask

  initial begin
    rst_n = 1'b0;
    depth16_i = 1'b0;
    cnt_mode_i = 2'b11;
    manual_sync_i = 1'b1;
    glatch_i = 1'b0;
    for (int c = 0; c < NCH; c++) words[c] = '0;
    t_reset();
    t_linear12();
    t_spread(2'b00, 65, 5, 64, 1, "R4");
    t_spread(2'b01, 17, 20, 16, 4, "R5");
    t_spread(2'b10, 5, 80, 4, 16, "R6");
    t_wide();
    t_manual();
    t_auto();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule